// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output logic cell of a small programmable logic device. It takes the product terms assigned to it from the logic array, ORs them into a single data bit, and sends that bit to the output either directly (combinational) or through a D flip-flop (registered), then optionally inverts it. A two-bit configuration word steers two multiplexers: one picks the path, the other picks the polarity.

The register has an asynchronous global clear term, a synchronous global set term, a power-up clear driven by the active-low reset, and a test preload path that writes a chosen value straight into the flip-flop. A dedicated output-enable term controls a tri-state pad model. A feedback bit goes back into the array. In registered mode it carries the flip-flop output. In combinational mode it carries the value seen at the pad, so a disabled output can serve as an input.

Top module: `pld_out_cell`

## Requirements
- R1: The cell data bit is the OR of all NUM_TERMS bits of `terms_i`. With `cfg_i` = 2'b10 (combinational, active high), `pin_o` equals that OR with no clock edge needed.
- R2: With `cfg_i[0]` = 1 (registered), the flip-flop captures the data bit on each rising clock edge, and the output changes only at that edge.
- R3: With `cfg_i[1]` = 0 (active low), `pin_o` is the inverse of the selected path value. With `cfg_i[1]` = 1, it is not inverted. Inversion follows the path multiplexer in both modes.
- R4: A high `gl_clr_i` clears the flip-flop at once, without a clock edge, and holds it at 0 while high.
- R5: A high `gl_set_i` sets the flip-flop to 1 only at a rising clock edge. Between edges it has no effect on the flip-flop.
- R6: When `gl_clr_i` and `gl_set_i` are high together, the flip-flop stays 0.
- R7: While `rst_ni` is low (the power-up pulse), the flip-flop is 0.
- R8: A high `preload_en_i` loads `preload_val_i` into the flip-flop at the next rising edge. This overrides both the data bit and `gl_set_i`. Polarity does not alter the stored value.
- R9: In registered mode, `fb_o` equals the flip-flop value. In combinational mode, `fb_o` equals the pad value.
- R10: `pin_en_o` follows `oe_term_i`. While it is low, the pad value is `pin_ext_i`, so combinational feedback returns the external level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock |
| rst_ni | input | 1 | Active-low asynchronous power-up clear |
| terms_i | input | NUM_TERMS | Product terms assigned to this cell |
| gl_clr_i | input | 1 | Global asynchronous clear term |
| gl_set_i | input | 1 | Global synchronous set term |
| oe_term_i | input | 1 | Output-enable product term |
| cfg_i | input | 2 | bit0: 1 registered / 0 combinational; bit1: 1 active high / 0 active low |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 1 | Test preload value |
| pin_ext_i | input | 1 | Level driven onto the pad from outside |
| pin_o | output | 1 | Value the cell drives onto the pad |
| pin_en_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback bit to the logic array |

## Verification
The bench builds the cell with NUM_TERMS = 12, which is wider than the default of 8. This makes it possible to drive a sum whose only active term is the most significant one, and to drive all terms at once, so an OR that drops an edge bit shows up. The flip-flop state is observed through the feedback bit in registered mode. This lets preload, clear and set be checked under both polarities without looking inside the design.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic {PATH_COMB = 1'b0, PATH_REG = 1'b1} path_e;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;

  typedef struct packed {
    pol_e  pol;
    path_e path;
  } cell_cfg_t;
endpackage

// File: rtl/pld_term_sum.sv
module pld_term_sum #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] terms_i,
  output logic                 sum_o
);
  always_comb begin
    sum_o = 1'b0;
    for (int i = 0; i < NUM_TERMS; i++) sum_o = sum_o | terms_i[i];
  end
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  output logic q_o
);
  logic clr_async;
  assign clr_async = ~rst_ni | clr_i;

  // clear > preload > set > data
  always_ff @(posedge clk_i or posedge clr_async) begin
    if (clr_async)    q_o <= 1'b0;
    else if (pl_en_i) q_o <= pl_val_i;
    else if (set_i)   q_o <= 1'b1;
    else              q_o <= d_i;
  end

  a_r4_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_o);
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!pl_en_i && !set_i) |=> q_o == $past(d_i));
  a_r5_set_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (set_i && !pl_en_i) |=> q_o);
  a_r8_preload: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    pl_en_i |=> q_o == $past(pl_val_i));
endmodule

// File: rtl/pld_cell_outmux.sv
module pld_cell_outmux
  import pld_cell_pkg::*;
(
  input  cell_cfg_t cfg_i,
  input  logic      comb_i,
  input  logic      q_i,
  output logic      out_o
);
  logic path_val;
  assign path_val = (cfg_i.path == PATH_REG) ? q_i : comb_i;
  assign out_o    = (cfg_i.pol == POL_HIGH) ? path_val : ~path_val;
endmodule

// File: rtl/pld_cell_pad.sv
module pld_cell_pad
  import pld_cell_pkg::*;
(
  input  cell_cfg_t cfg_i,
  input  logic      oe_i,
  input  logic      drv_i,
  input  logic      ext_i,
  input  logic      q_i,
  output logic      pin_o,
  output logic      pin_en_o,
  output logic      fb_o
);
  logic pad_val;
  assign pin_o    = drv_i;
  assign pin_en_o = oe_i;
  assign pad_val  = oe_i ? drv_i : ext_i;
  assign fb_o     = (cfg_i.path == PATH_REG) ? q_i : pad_val;
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_TERMS-1:0] terms_i,
  input  logic                 gl_clr_i,
  input  logic                 gl_set_i,
  input  logic                 oe_term_i,
  input  logic [1:0]           cfg_i,
  input  logic                 preload_en_i,
  input  logic                 preload_val_i,
  input  logic                 pin_ext_i,
  output logic                 pin_o,
  output logic                 pin_en_o,
  output logic                 fb_o
);
  cell_cfg_t cfg;
  logic      sum, q, drv;

  assign cfg = cell_cfg_t'(cfg_i);

  pld_term_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (.terms_i(terms_i), .sum_o(sum));

  pld_cell_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sum), .clr_i(gl_clr_i), .set_i(gl_set_i),
    .pl_en_i(preload_en_i), .pl_val_i(preload_val_i), .q_o(q)
  );

  pld_cell_outmux u_mux (.cfg_i(cfg), .comb_i(sum), .q_i(q), .out_o(drv));

  pld_cell_pad u_pad (
    .cfg_i(cfg), .oe_i(oe_term_i), .drv_i(drv), .ext_i(pin_ext_i), .q_i(q),
    .pin_o(pin_o), .pin_en_o(pin_en_o), .fb_o(fb_o)
  );

  a_r1_comb_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b10) |-> pin_o == (|terms_i));
  a_r3_comb_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b00) |-> pin_o != (|terms_i));
  a_r9_fb_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b11) |-> fb_o == pin_o);
  a_r10_fb_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_term_i && !cfg_i[0]) |-> fb_o == pin_ext_i);
endmodule

// File: tb/pld_out_cell_test.sv
module pld_out_cell_test;
  localparam int NT = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [NT-1:0] terms_i = '0;
  logic          gl_clr_i = 1'b0, gl_set_i = 1'b0, oe_term_i = 1'b1;
  logic [1:0]    cfg_i = 2'b11;
  logic          preload_en_i = 1'b0, preload_val_i = 1'b0, pin_ext_i = 1'b0;
  logic          pin_o, pin_en_o, fb_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  pld_out_cell #(.NUM_TERMS(NT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .terms_i(terms_i), .gl_clr_i(gl_clr_i),
    .gl_set_i(gl_set_i), .oe_term_i(oe_term_i), .cfg_i(cfg_i),
    .preload_en_i(preload_en_i), .preload_val_i(preload_val_i),
    .pin_ext_i(pin_ext_i), .pin_o(pin_o), .pin_en_o(pin_en_o), .fb_o(fb_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edge_settle();
    @(posedge clk_i); #1;
  endtask

  task automatic t_powerup();
    #1 rst_ni = 1'b0;
    #2;
    chk("R7 fb during reset", fb_o, 1'b0);
    cfg_i = 2'b01; #1;
    chk("R7 active-low pin during reset", pin_o, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1; cfg_i = 2'b11;
  endtask

  task automatic t_comb();
    @(negedge clk_i); cfg_i = 2'b10; terms_i = '0; #1;
    chk("R1 no terms", pin_o, 1'b0);
    terms_i[NT-1] = 1'b1; #1;
    chk("R1 top term only", pin_o, 1'b1);
    terms_i = '1; #1;
    chk("R1 all terms", pin_o, 1'b1);
    terms_i = 12'h001; cfg_i = 2'b00; #1;
    chk("R3 comb active-low", pin_o, 1'b0);
    terms_i = '0; #1;
    chk("R3 comb active-low zero", pin_o, 1'b1);
  endtask

  task automatic t_reg();
    @(negedge clk_i); cfg_i = 2'b11; terms_i = 12'h010;
    edge_settle();
    chk("R2 captured 1", pin_o, 1'b1);
    @(negedge clk_i); terms_i = '0; #1;
    chk("R2 holds between edges", pin_o, 1'b1);
    edge_settle();
    chk("R2 captured 0", pin_o, 1'b0);
    @(negedge clk_i); cfg_i = 2'b01; terms_i = 12'h800;
    edge_settle();
    chk("R3 reg active-low pin", pin_o, 1'b0);
    chk("R9 reg fb is flop", fb_o, 1'b1);
  endtask

  task automatic t_clear_set();
    @(negedge clk_i); cfg_i = 2'b11; terms_i = 12'h002;
    edge_settle();
    #2 gl_clr_i = 1'b1; #1;
    chk("R4 async clear", fb_o, 1'b0);
    edge_settle();
    chk("R4 clear held", fb_o, 1'b0);
    @(negedge clk_i); gl_clr_i = 1'b0; terms_i = '0; gl_set_i = 1'b1; #1;
    chk("R5 no set before edge", fb_o, 1'b0);
    edge_settle();
    chk("R5 set at edge", fb_o, 1'b1);
    @(negedge clk_i); gl_set_i = 1'b0;
    edge_settle();
    chk("R5 data resumes", fb_o, 1'b0);
    @(negedge clk_i); gl_set_i = 1'b1; gl_clr_i = 1'b1;
    edge_settle();
    chk("R6 clear beats set", fb_o, 1'b0);
    @(negedge clk_i); gl_set_i = 1'b0; gl_clr_i = 1'b0;
  endtask

  task automatic t_preload();
    @(negedge clk_i); cfg_i = 2'b01; terms_i = '0;
    preload_en_i = 1'b1; preload_val_i = 1'b1;
    edge_settle();
    chk("R8 preload stored", fb_o, 1'b1);
    chk("R8 preload pin active-low", pin_o, 1'b0);
    @(negedge clk_i); preload_val_i = 1'b0; gl_set_i = 1'b1; terms_i = '1;
    edge_settle();
    chk("R8 preload over set", fb_o, 1'b0);
    @(negedge clk_i); cfg_i = 2'b11; preload_val_i = 1'b1; gl_set_i = 1'b0; terms_i = '0;
    edge_settle();
    chk("R8 preload active-high", pin_o, 1'b1);
    @(negedge clk_i); preload_en_i = 1'b0;
  endtask

  task automatic t_oe();
    @(negedge clk_i); cfg_i = 2'b10; terms_i = 12'h004; oe_term_i = 1'b0; pin_ext_i = 1'b0; #1;
    chk("R10 enable low", pin_en_o, 1'b0);
    chk("R10 fb ext 0", fb_o, 1'b0);
    pin_ext_i = 1'b1; terms_i = '0; #1;
    chk("R10 fb ext 1", fb_o, 1'b1);
    oe_term_i = 1'b1; cfg_i = 2'b00; terms_i = 12'h004; #1;
    chk("R10 enable high", pin_en_o, 1'b1);
    chk("R9 comb fb is pad", fb_o, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_powerup();
        t_comb();
        t_reg();
        t_clear_set();
        t_preload();
        t_oe();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule